// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block turns one fast source into three banks of four divided clocks plus one feedback clock. The source is a stream of edge strobes: the oscillator strobe in normal operation, or the reference strobe when bypass is selected. A shared pre-scaler either halves the selected strobe stream or passes it through. Each bank then divides by an even ratio picked from its own table with a small select field. All outputs run at an exact 50% duty cycle.

Two of the four outputs in the third bank can be inverted to give a half-period phase shift against their siblings. An active-low run input acts as a clear: while it is low every output is held low and every counter is reset. After it rises, all banks take their first rising edge on the same advancing source strobe, so the rising edges of the banks stay aligned. A 12-bit stop mask silences single outputs, holding them low. A stop or restart only takes effect while the output is low, so no output ever shows a short pulse.

The block is fully synchronous to `clk`. Each strobe marks one source edge. With no strobes arriving, the block is static.

Top module: `clkdiv_banks`

## Requirements
- R1: With `fullRate`=0 the dividers advance on every second selected strobe, which doubles every output period. With `fullRate`=1 they advance on every selected strobe.
- R2: Bank A divides the pre-scaled stream by 4, 6, 8 or 12 for `selA` = 0, 1, 2, 3.
- R3: Bank B divides the pre-scaled stream by 4, 6, 8 or 10 for `selB` = 0, 1, 2, 3.
- R4: Bank C divides the pre-scaled stream by 2, 4, 6 or 8 for `selC` = 0, 1, 2, 3.
- R5: The feedback output divides the pre-scaled stream by 4, 6, 8 or 10 for `selFb` = 0..3 and by 8, 12, 16 or 20 for `selFb` = 4..7.
- R6: With `invC`=1, `qC[2]` and `qC[3]` are the complements of `qC[0]` and `qC[1]`. With `invC`=0, all four bank C outputs are identical.
- R7: While `runEn` is low, from the next clock on, all 13 outputs are low and all divider state is cleared.
- R8: With `bypass`=1 only `refTick` advances the dividers. With `bypass`=0 only `vcoTick` advances them. With no selected strobe, the outputs do not change.
- R9: Setting stop-mask bit i holds one output low, and clearing the bit lets it run again. Bits 0-3 map to `qA[0..3]`, bits 4-7 map to `qB[0..3]`, and bits 8-11 map to `qC[0..3]`. The feedback output is never stopped.
- R10: Every high pulse of every output lasts exactly half its period. Stopping or restarting never cuts a pulse short.
- R11: After `runEn` rises, all outputs that are not inverted go high for the first time on the same clock. Banks with equal total ratio produce identical waveforms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| runEn | input | 1 | Active-low clear: low forces outputs low and resets the dividers |
| bypass | input | 1 | 1 selects `refTick` as the source, 0 selects `vcoTick` |
| vcoTick | input | 1 | One-cycle strobe per oscillator edge |
| refTick | input | 1 | One-cycle strobe per reference edge |
| fullRate | input | 1 | 1 passes the source through, 0 halves it |
| selA | input | 2 | Bank A ratio select |
| selB | input | 2 | Bank B ratio select |
| selC | input | 2 | Bank C ratio select |
| selFb | input | 3 | Feedback ratio select |
| invC | input | 1 | Inverts `qC[2]` and `qC[3]` |
| stopMask | input | 12 | Per-output stop bits |
| qA | output | 4 | Bank A clocks |
| qB | output | 4 | Bank B clocks |
| qC | output | 4 | Bank C clocks |
| qFb | output | 1 | Feedback clock |

## Verification
The assertions check the following on every cycle:
- outputs go low one clock after `runEn` falls;
- the halving pre-scaler never advances on two strobes in a row;
- the inverted pair and its siblings are never high together;
- the feedback phase holds while no strobe is selected;
- a stopped output that is low stays low;
- every output edge coincides with an edge of its divider phase, so gating cannot clip a pulse.

The exact ratio of each select code, the bypass source choice, and the first-edge alignment after release can only be shown by the bench scenarios. These scenarios count high samples and rising edges over windows that are whole multiples of each period. They also record the lengths of pulses while the stop mask toggles at arbitrary phases.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;  // hold dividers cleared
    logic adv;  // advance every divider by one pre-scaled edge
  } stepT;

  localparam int BANK_A  = 0;
  localparam int BANK_B  = 1;
  localparam int BANK_C  = 2;
  localparam int BANK_FB = 3;

  // half of the divide ratio, in pre-scaled edges
  function automatic int unsigned halfOf(input int bank, input logic [2:0] sel);
    int unsigned h;
    h = 1;
    case (bank)
      BANK_A: case (sel[1:0])
                2'd0: h = 2;
                2'd1: h = 3;
                2'd2: h = 4;
                default: h = 6;
              endcase
      BANK_B: h = 32'(sel[1:0]) + 2;
      BANK_C: h = 32'(sel[1:0]) + 1;
      default: h = (32'(sel[1:0]) + 2) << sel[2];
    endcase
    return h;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl.sv
`timescale 1ns/1ps
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic bypass,
  input  logic vcoTick,
  input  logic refTick,
  input  logic fullRate,
  output stepT step
);

  logic runQ;
  logic preTog;
  logic srcTick;

  assign srcTick = bypass ? refTick : vcoTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ   <= 1'b0;
      preTog <= 1'b0;
    end else begin
      runQ <= runEn;
      if (!runQ || fullRate) begin
        preTog <= 1'b0;
      end else if (srcTick) begin
        preTog <= ~preTog;
      end
    end
  end

  always_comb begin
    step.clr = ~runQ;
    step.adv = runQ & srcTick & (fullRate | preTog);
  end

endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int BANK_ID = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  stepT       step,
  input  logic [2:0] sel,
  output logic       phase
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] term;

  always_comb begin
    term = CNT_W'(halfOf(BANK_ID, sel) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (step.clr) begin
      // preload the terminal count so the first advance raises every bank
      cnt   <= term;
      phase <= 1'b0;
    end else if (step.adv) begin
      if (cnt >= term) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkdiv_dp.sv
`timescale 1ns/1ps
module clkdiv_dp
  import clkdiv_pkg::*;
#(
  parameter int OUT_PER_BANK = 4,
  parameter int CNT_W        = 4,
  localparam int NUM_OUT     = 3 * OUT_PER_BANK,
  localparam int NUM_BANK    = 4,
  localparam int INV_FIRST   = OUT_PER_BANK / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepT             step,
  input  logic [1:0]       selA,
  input  logic [1:0]       selB,
  input  logic [1:0]       selC,
  input  logic [2:0]       selFb,
  input  logic             invC,
  output logic [NUM_OUT:0] phaseVec
);

  logic [2:0]          selArr [NUM_BANK];
  logic [NUM_BANK-1:0] bankPhase;

  always_comb begin
    selArr[BANK_A]  = {1'b0, selA};
    selArr[BANK_B]  = {1'b0, selB};
    selArr[BANK_C]  = {1'b0, selC};
    selArr[BANK_FB] = selFb;
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    clkdiv_bank #(
      .CNT_W  (CNT_W),
      .BANK_ID(b)
    ) u_bank (
      .clk  (clk),
      .rstN (rstN),
      .step (step),
      .sel  (selArr[b]),
      .phase(bankPhase[b])
    );
  end

  for (genvar b = 0; b < 3; b++) begin : g_fan
    for (genvar k = 0; k < OUT_PER_BANK; k++) begin : g_out
      if (b == BANK_C && k >= INV_FIRST) begin : g_inv
        assign phaseVec[b*OUT_PER_BANK + k] = bankPhase[b] ^ invC;
      end else begin : g_dir
        assign phaseVec[b*OUT_PER_BANK + k] = bankPhase[b];
      end
    end
  end

  assign phaseVec[NUM_OUT] = bankPhase[BANK_FB];

endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
  parameter int NUM_OUT = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clear,
  input  logic [NUM_OUT-1:0] stopMask,
  input  logic [NUM_OUT:0]   phaseVec,
  output logic [NUM_OUT:0]   outVec
);

  logic [NUM_OUT-1:0] gateOn;

  // a gate bit only moves while its phase is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateOn <= '1;
    end else if (clear) begin
      gateOn <= ~stopMask;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (!phaseVec[i]) gateOn[i] <= ~stopMask[i];
      end
    end
  end

  always_comb begin
    outVec[NUM_OUT-1:0] = phaseVec[NUM_OUT-1:0] & gateOn & {NUM_OUT{~clear}};
    outVec[NUM_OUT]     = phaseVec[NUM_OUT] & ~clear;
  end

endmodule

// File: rtl/clkdiv_banks.sv
`timescale 1ns/1ps
module clkdiv_banks
  import clkdiv_pkg::*;
#(
  parameter int OUT_PER_BANK = 4,
  parameter int CNT_W        = 4,
  localparam int NUM_OUT     = 3 * OUT_PER_BANK
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    runEn,
  input  logic                    bypass,
  input  logic                    vcoTick,
  input  logic                    refTick,
  input  logic                    fullRate,
  input  logic [1:0]              selA,
  input  logic [1:0]              selB,
  input  logic [1:0]              selC,
  input  logic [2:0]              selFb,
  input  logic                    invC,
  input  logic [NUM_OUT-1:0]      stopMask,
  output logic [OUT_PER_BANK-1:0] qA,
  output logic [OUT_PER_BANK-1:0] qB,
  output logic [OUT_PER_BANK-1:0] qC,
  output logic                    qFb
);

  stepT             step;
  logic [NUM_OUT:0] phaseVec;
  logic [NUM_OUT:0] outVec;

  clkdiv_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .runEn   (runEn),
    .bypass  (bypass),
    .vcoTick (vcoTick),
    .refTick (refTick),
    .fullRate(fullRate),
    .step    (step)
  );

  clkdiv_dp #(
    .OUT_PER_BANK(OUT_PER_BANK),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .step    (step),
    .selA    (selA),
    .selB    (selB),
    .selC    (selC),
    .selFb   (selFb),
    .invC    (invC),
    .phaseVec(phaseVec)
  );

  clkdiv_gate #(
    .NUM_OUT(NUM_OUT)
  ) u_gate (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (step.clr),
    .stopMask(stopMask),
    .phaseVec(phaseVec),
    .outVec  (outVec)
  );

  assign qA  = outVec[OUT_PER_BANK-1:0];
  assign qB  = outVec[2*OUT_PER_BANK-1:OUT_PER_BANK];
  assign qC  = outVec[NUM_OUT-1:2*OUT_PER_BANK];
  assign qFb = outVec[NUM_OUT];

endmodule

// File: rtl/clkdiv_banks_chk.sv
`timescale 1ns/1ps
module clkdiv_banks_chk
  import clkdiv_pkg::*;
#(
  parameter int OUT_PER_BANK = 4,
  localparam int NUM_OUT     = 3 * OUT_PER_BANK,
  localparam int INV_FIRST   = OUT_PER_BANK / 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    runEn,
  input logic                    fullRate,
  input logic                    invC,
  input stepT                    step,
  input logic [NUM_OUT-1:0]      stopMask,
  input logic [NUM_OUT:0]        phaseVec,
  input logic [OUT_PER_BANK-1:0] qA,
  input logic [OUT_PER_BANK-1:0] qB,
  input logic [OUT_PER_BANK-1:0] qC,
  input logic                    qFb
);

  logic [NUM_OUT:0] qAll;
  assign qAll = {qFb, qC, qB, qA};

  assert_half_rate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!fullRate && step.adv) |=> (fullRate || !step.adv));

  assert_inv_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    invC |-> !(qC[0] && qC[INV_FIRST]));

  assert_clear_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (qAll == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!step.adv && !step.clr) |=> $stable(phaseVec[NUM_OUT]));

  for (genvar i = 0; i <= NUM_OUT; i++) begin : g_out
    if (i < NUM_OUT) begin : g_stop
      assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
        (stopMask[i] && !qAll[i]) |=> !qAll[i]);
    end
    assert_whole_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
      ($past(!step.clr) && !step.clr && $rose(qAll[i])) |-> $rose(phaseVec[i]));
    assert_no_trunc_R10: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(qAll[i]) && !step.clr) |-> $fell(phaseVec[i]));
  end

endmodule

bind clkdiv_banks clkdiv_banks_chk #(.OUT_PER_BANK(OUT_PER_BANK)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .runEn   (runEn),
  .fullRate(fullRate),
  .invC    (invC),
  .step    (step),
  .stopMask(stopMask),
  .phaseVec(phaseVec),
  .qA      (qA),
  .qB      (qB),
  .qC      (qC),
  .qFb     (qFb)
);

// File: tb/clkdiv_banks_bench.sv
`timescale 1ns/1ps
module clkdiv_banks_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        bypass = 1'b0;
  logic        vcoTick = 1'b0;
  logic        refTick = 1'b0;
  logic        fullRate = 1'b0;
  logic [1:0]  selA = '0, selB = '0, selC = '0;
  logic [2:0]  selFb = '0;
  logic        invC = 1'b0;
  logic [11:0] stopMask = '0;
  logic [3:0]  qA, qB, qC;
  logic        qFb;

  logic        vcoOn = 1'b1;
  logic        refOn = 1'b0;
  logic [15:0] tcnt = '0;

  int total = 0;
  int bad = 0;
  int highCnt [13];
  int riseCnt [13];
  int minRun  [13];
  int maxRun  [13];

  wire [12:0] allOut = {qFb, qC, qB, qA};

  always #10 clk = ~clk;

  clkdiv_banks u_clkdiv_banks (
    .clk(clk), .rstN(rstN), .runEn(runEn), .bypass(bypass),
    .vcoTick(vcoTick), .refTick(refTick), .fullRate(fullRate),
    .selA(selA), .selB(selB), .selC(selC), .selFb(selFb),
    .invC(invC), .stopMask(stopMask),
    .qA(qA), .qB(qB), .qC(qC), .qFb(qFb)
  );

  // source strobes, driven away from the active edge
  always @(negedge clk) begin
    tcnt    <= tcnt + 1'b1;
    vcoTick <= vcoOn;
    refTick <= refOn && tcnt[0];
  end

  function automatic int ratioOf(input int bank, input int sel);
    case (bank)
      0: case (sel) 0: return 4; 1: return 6; 2: return 8; default: return 12; endcase
      1: return 4 + 2 * sel;
      2: return 2 + 2 * sel;
      default: return (4 + 2 * (sel % 4)) * ((sel >= 4) ? 2 : 1);
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input bit full, input bit byp, input bit vOn, input bit rOn,
                       input int a, input int b, input int c, input int f,
                       input bit inv, input logic [11:0] m);
    @(negedge clk);
    runEn = 1'b0;
    fullRate = full; bypass = byp; vcoOn = vOn; refOn = rOn;
    selA = 2'(a); selB = 2'(b); selC = 2'(c); selFb = 3'(f);
    invC = inv; stopMask = m;
    repeat (3) @(negedge clk);
    runEn = 1'b1;
    repeat (60) @(negedge clk);
  endtask

  task automatic measure(input int n);
    logic [12:0] prev, cur;
    int run [13];
    bit trk [13];
    for (int i = 0; i < 13; i++) begin
      highCnt[i] = 0; riseCnt[i] = 0; minRun[i] = 1 << 20; maxRun[i] = 0;
      run[i] = 0; trk[i] = 0;
    end
    @(negedge clk);
    prev = allOut;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      cur = allOut;
      for (int i = 0; i < 13; i++) begin
        if (cur[i]) highCnt[i]++;
        if (cur[i] && !prev[i]) begin
          riseCnt[i]++; run[i] = 1; trk[i] = 1;
        end else if (cur[i] && prev[i]) begin
          run[i]++;
        end else if (!cur[i] && prev[i] && trk[i]) begin
          if (run[i] < minRun[i]) minRun[i] = run[i];
          if (run[i] > maxRun[i]) maxRun[i] = run[i];
        end
      end
      prev = cur;
    end
  endtask

  task automatic checkPeriod(input int idx, input int per, input int win, input string tag);
    check(highCnt[idx] == win / 2, $sformatf("%s duty out%0d", tag, idx), highCnt[idx], win / 2);
    check(riseCnt[idx] == win / per, $sformatf("%s period out%0d", tag, idx), riseCnt[idx], win / per);
  endtask

  // R7: outputs low while held in clear
  task automatic t_reset();
    int sum;
    check(allOut == 13'd0, "R7 after power-on reset", int'(allOut), 0);
    @(negedge clk);
    runEn = 1'b0;
    measure(50);
    sum = 0;
    for (int i = 0; i < 13; i++) sum += highCnt[i];
    check(sum == 0, "R7 highs while cleared", sum, 0);
  endtask

  // R1..R5: every select code at both pre-scale settings
  task automatic t_ratios();
    for (int fr = 0; fr < 2; fr++) begin
      for (int f = 0; f < 8; f++) begin
        int sel = f % 4;
        int pre = (fr == 1) ? 1 : 2;  // R1 halving doubles periods
        apply(fr[0], 1'b0, 1'b1, 1'b0, sel, sel, sel, f, 1'b0, 12'h000);
        measure(480);
        checkPeriod(0,  ratioOf(0, sel) * pre, 480, $sformatf("R2 R1 pre=%0d", pre));
        checkPeriod(7,  ratioOf(1, sel) * pre, 480, $sformatf("R3 R1 pre=%0d", pre));
        checkPeriod(9,  ratioOf(2, sel) * pre, 480, $sformatf("R4 R1 pre=%0d", pre));
        checkPeriod(12, ratioOf(3, f) * pre,   480, $sformatf("R5 R1 pre=%0d", pre));
      end
    end
  endtask

  // R8: source selection
  task automatic t_bypass();
    apply(1'b1, 1'b1, 1'b0, 1'b1, 1, 1, 1, 1, 1'b0, 12'h000);
    measure(480);
    checkPeriod(0, 12, 480, "R8 ref source bankA");
    checkPeriod(12, 12, 480, "R8 ref source fb");
    apply(1'b1, 1'b1, 1'b1, 1'b0, 1, 1, 1, 1, 1'b0, 12'h000);
    measure(200);
    check(highCnt[0] == 0 && highCnt[12] == 0, "R8 oscillator ignored in bypass",
          highCnt[0] + highCnt[12], 0);
    apply(1'b1, 1'b0, 1'b0, 1'b1, 1, 1, 1, 1, 1'b0, 12'h000);
    measure(200);
    check(highCnt[4] == 0 && highCnt[12] == 0, "R8 reference ignored without bypass",
          highCnt[4] + highCnt[12], 0);
  endtask

  // R6: phase of the inverted pair
  task automatic t_invert();
    int mis;
    apply(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 1, 0, 1'b1, 12'h000);
    mis = 0;
    for (int s = 0; s < 200; s++) begin
      @(negedge clk);
      if (qC[2] != ~qC[0] || qC[3] != ~qC[1] || qC[1] != qC[0]) mis++;
    end
    check(mis == 0, "R6 inverted pair opposite", mis, 0);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 1, 0, 1'b0, 12'h000);
    mis = 0;
    for (int s = 0; s < 200; s++) begin
      @(negedge clk);
      if (qC != {4{qC[0]}}) mis++;
    end
    check(mis == 0, "R6 bank C in phase", mis, 0);
  endtask

  // R9, R10: stop gating and whole pulses
  task automatic t_stop();
    apply(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 0, 0, 1'b0, 12'h420);
    measure(480);
    check(highCnt[5] == 0, "R9 qB1 stopped", highCnt[5], 0);
    check(highCnt[10] == 0, "R9 qC2 stopped", highCnt[10], 0);
    check(highCnt[4] == 240, "R9 qB0 unaffected", highCnt[4], 240);
    check(highCnt[12] == 240, "R9 feedback unaffected", highCnt[12], 240);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 0, 0, 0, 0, 1'b0, 12'h000);
    fork
      measure(480);
      begin
        repeat (53) @(negedge clk); stopMask = 12'h420;
        repeat (97) @(negedge clk); stopMask = 12'h000;
        repeat (131) @(negedge clk); stopMask = 12'h420;
        repeat (67) @(negedge clk); stopMask = 12'h000;
      end
    join
    check(highCnt[5] > 0 && highCnt[5] < 240, "R9 qB1 restarts", highCnt[5], 120);
    check(minRun[5] == 4 && maxRun[5] == 4, "R10 qB1 pulse width", minRun[5], 4);
    check(minRun[10] == 2 && maxRun[10] == 2, "R10 qC2 pulse width", minRun[10], 2);
  endtask

  // R11: aligned first rise after release
  task automatic t_align();
    int first [13];
    int mis;
    @(negedge clk);
    runEn = 1'b0; fullRate = 1'b0; bypass = 1'b0; vcoOn = 1'b1; refOn = 1'b0;
    selA = 2'd3; selB = 2'd1; selC = 2'd2; selFb = 3'd5; invC = 1'b0; stopMask = '0;
    repeat (4) @(negedge clk);
    runEn = 1'b1;
    for (int i = 0; i < 13; i++) first[i] = -1;
    for (int s = 0; s < 100; s++) begin
      @(negedge clk);
      for (int i = 0; i < 13; i++) if (allOut[i] && first[i] < 0) first[i] = s;
    end
    check(first[0] >= 0, "R11 outputs start", first[0], 0);
    mis = 0;
    for (int i = 0; i < 13; i++) if (first[i] != first[0]) mis++;
    check(mis == 0, "R11 first rises aligned", mis, 0);
    mis = 0;
    for (int s = 0; s < 240; s++) begin
      @(negedge clk);
      if (qA[0] != qFb) mis++;
    end
    check(mis == 0, "R11 equal ratios identical", mis, 0);
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratios();
    t_bypass();
    t_invert();
    t_stop();
    t_align();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule